// File: doc/BRIEF.md
# Sticky Event Status Register with Alarm Interrupt

This block keeps an 8-bit status register that records two hardware events in sticky flags: one for an oscillator stop and one for an alarm countdown reaching zero. Each flag is set by a single-cycle event pulse and stays set until software writes 0 to its bit through a simple register bus. The oscillator flag comes out of reset already set, so that software can tell the timekeeping data has not yet been validated.

The alarm flag also drives an active-low interrupt line. The line is asserted only while the alarm flag is set and two separate enables are high: the alarm interrupt enable and the interrupt-select control. It stays low until software clears the flag. When a set event and a software clear reach the same flag in the same cycle, the set wins, so no event is lost. The serial host interface, the oscillator and the alarm counter are outside this block. The alarm counter is seen only as a pulse input.

Top module: `stat_flag_reg`

## Requirements
- R1: After reset the status register reads 0x80: the oscillator-stop flag (bit 7) is 1 and the alarm flag (bit 0) is 0. The interrupt output `irq_no` is 1.
- R2: A cycle with `osc_stop_i` high sets bit 7 on the next clock edge.
- R3: A cycle with `alarm_zero_i` high sets bit 0 on the next clock edge.
- R4: A write to address 0x08 with a 0 in bit 7 or bit 0 clears that flag on the next clock edge.
- R5: A write to address 0x08 with a 1 in bit 7 or bit 0 leaves that flag unchanged.
- R6: Bits 6 through 1 always read as 0, whatever value was written to them.
- R7: When a set event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R8: `irq_no` is 0 exactly when the alarm flag is 1 and both `alarm_ie_i` and `int_sel_i` are 1. If either enable is 0, `irq_no` is 1.
- R9: A write to any address other than 0x08 does not change either flag. A read from any other address returns 0x00.
- R10: `rd_data_o` equals the status register contents whenever `addr_i` is 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_stop_i | input | 1 | Oscillator-stop event pulse |
| alarm_zero_i | input | 1 | Alarm counter reached zero, pulse |
| alarm_ie_i | input | 1 | Alarm interrupt enable |
| int_sel_i | input | 1 | Interrupt-select control; the pin acts as an interrupt only when this is 1 |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, combinational from `addr_i` |
| status_o | output | 8 | Status register contents |
| irq_no | output | 1 | Interrupt, active low |

## Verification
On every cycle the assertions check the flag-cell rules: an event sets its flag, a clearing write without an event drops it, and a write of 1 or a write to another address holds it. They also check that the interrupt pin follows the alarm flag gated by both enables, and that the reserved bits stay zero. The value after reset, the ordering of clears against later events, and the readback through the address decode can only be shown by the bench's scenarios. Those scenarios compare the outputs with values the bench derives itself.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 8;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h08;
  localparam int unsigned OSF_BIT   = 7;
  localparam int unsigned ALF_BIT   = 0;
endpackage

// File: rtl/stat_flag_cell.sv
module stat_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_wr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= RST_VAL;
    else if (set_i)  flag_q <= 1'b1;   // set beats clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r2_r3_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  a_r5_one_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_wr_i && !set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/stat_irq_gate.sv
module stat_irq_gate (
  input  logic flag_i,
  input  logic ie_i,
  input  logic sel_i,
  output logic irq_no
);
  assign irq_no = ~(flag_i & ie_i & sel_i);
endmodule

// File: rtl/stat_flag_reg.sv
module stat_flag_reg
  import stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_stop_i,
  input  logic              alarm_zero_i,
  input  logic              alarm_ie_i,
  input  logic              int_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_no
);
  logic hit, stat_wr, osf, alf;

  assign hit     = (addr_i == STAT_ADDR);
  assign stat_wr = wr_en_i & hit;

  stat_flag_cell #(.RST_VAL(1'b1)) u_osf (
    .clk_i, .rst_ni,
    .set_i    (osc_stop_i),
    .clr_i    (stat_wr & ~wr_data_i[OSF_BIT]),
    .hold_wr_i(wr_en_i & (~hit | wr_data_i[OSF_BIT])),
    .flag_o   (osf)
  );

  stat_flag_cell #(.RST_VAL(1'b0)) u_alf (
    .clk_i, .rst_ni,
    .set_i    (alarm_zero_i),
    .clr_i    (stat_wr & ~wr_data_i[ALF_BIT]),
    .hold_wr_i(wr_en_i & (~hit | wr_data_i[ALF_BIT])),
    .flag_o   (alf)
  );

  always_comb begin
    status_o          = '0;
    status_o[OSF_BIT] = osf;
    status_o[ALF_BIT] = alf;
  end

  assign rd_data_o = hit ? status_o : '0;

  stat_irq_gate u_irq (
    .flag_i(alf), .ie_i(alarm_ie_i), .sel_i(int_sel_i), .irq_no(irq_no)
  );

  a_r6_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[OSF_BIT-1:ALF_BIT+1] == '0);
  a_r8_irq_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ALF_BIT] && alarm_ie_i && int_sel_i) |-> !irq_no);
  a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alarm_ie_i || !int_sel_i || !status_o[ALF_BIT]) |-> irq_no);
  a_r9_other_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit && !osc_stop_i && !alarm_zero_i) |=> $stable(status_o));
endmodule

// File: tb/stat_flag_reg_test.sv
module stat_flag_reg_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 12;
  // {osc, alarm, aie, sel, wr, addr[8], wdata[8], exp_status[8], exp_irq}
  localparam logic [29:0] VEC [NVEC] = '{
    {5'b00000, 8'h08, 8'h00, 8'h80, 1'b1},  // R1 idle after reset
    {5'b00001, 8'h08, 8'hFF, 8'h80, 1'b1},  // R5 write ones
    {5'b00001, 8'h08, 8'h00, 8'h00, 1'b1},  // R4 clear osc
    {5'b01000, 8'h08, 8'h00, 8'h01, 1'b1},  // R3 alarm, R8 enables off
    {5'b00100, 8'h08, 8'h00, 8'h01, 1'b1},  // R8 sel off
    {5'b00110, 8'h08, 8'h00, 8'h01, 1'b0},  // R8 both on
    {5'b00111, 8'h08, 8'hFE, 8'h00, 1'b1},  // R4 clear alarm
    {5'b10000, 8'h08, 8'h00, 8'h80, 1'b1},  // R2 osc event
    {5'b00001, 8'h07, 8'h00, 8'h80, 1'b1},  // R9 other address
    {5'b10001, 8'h08, 8'h00, 8'h80, 1'b1},  // R7 osc set beats clear
    {5'b01111, 8'h08, 8'h00, 8'h01, 1'b0},  // R7 alarm set beats clear
    {5'b00111, 8'h08, 8'h7E, 8'h00, 1'b1}   // R6 reserved ones ignored
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc = 0, alm = 0, aie = 0, sel = 0, wr = 0;
  logic [7:0] addr = 8'h08, wdata = '0, rdata, status;
  logic irq_n;
  int errors = 0, checks = 0;

  stat_flag_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .osc_stop_i(osc), .alarm_zero_i(alm),
    .alarm_ie_i(aie), .int_sel_i(sel), .addr_i(addr), .wr_en_i(wr),
    .wr_data_i(wdata), .rd_data_o(rdata), .status_o(status), .irq_no(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check8("R1 status", status, 8'h80);
    check8("R1 irq", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {osc, alm, aie, sel, wr, addr, wdata} = VEC[i][29:9];
      @(negedge clk);
      osc = 0; alm = 0; wr = 0;
      check8($sformatf("R2-vector %0d status", i), status, VEC[i][8:1]);
      check8($sformatf("R8 vector %0d irq", i), {7'd0, irq_n}, {7'd0, VEC[i][0]});
    end
    // R10 readback at the status address, R6 reserved bits
    @(negedge clk); osc = 1;
    @(negedge clk); osc = 0; addr = 8'h08; #1;
    check8("R10 readback", rdata, 8'h80);
    check8("R6 reserved", rdata & 8'h7E, 8'h00);
    // R9 read at another address
    addr = 8'h09; #1;
    check8("R9 read other", rdata, 8'h00);
    // R1 reset mid-run with both flags set
    @(negedge clk); alm = 1;
    @(negedge clk); alm = 0; check8("R3 alarm set", status, 8'h81);
    rst_n = 0; #1;
    check8("R1 async reset", status, 8'h80);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check8("R1 after release", status, 8'h80);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule